// File: doc/BRIEF.md
# SPI Register-Access Target with Wait States

The block is an SPI target in mode 0 (SCLK idles low, MOSI sampled on the rising edge, MISO changed on the falling edge). It gives an SPI host read and write access to a local register space. The target oversamples all SPI pins in the system clock domain. Every transaction begins with a four-byte header. The first byte holds the direction and the payload length. The next three bytes hold a 24-bit address. A fixed window base is subtracted from that address to form the local register offset.

Wait states are possible at exactly one point. The target chooses bit 0 of the fourth MISO byte. If that bit is 0, the host keeps clocking filler bytes and looks at bit 0 of each one until it reads 1. Reads must stall, because the target only starts fetching when the header completes. It fills a local buffer through a request/acknowledge port with variable latency. It then releases the stall and streams the data. Writes never stall. The payload is captured into the same buffer and committed to the local port after chip select rises. An oversized burst puts the target into an error state until chip select rises.

Top module: `spi_reg_target`

## Requirements
- R1: Header byte 0 bit 7 set means read and clear means write; bits 5:0 hold length minus one (1..64 bytes); header bytes 1, 2, 3 hold the address, most significant byte first.
- R2: The local offset is the received address minus 0xD40000, modulo 2^24; payload byte i is accessed at offset + i.
- R3: MISO header bytes 1..3 are 0x00. The fourth MISO byte is 0x01 for a write (no stall) and 0x00 for a read (stall).
- R4: During a read stall, each polled byte is 0x00 until every requested byte has been acknowledged locally. Then the target sends one 0x01 byte, and the payload starts on the next byte. No wait byte follows once 0x01 has been sent.
- R5: Read payload bytes are sent MSB first, in address order. Bytes clocked beyond the requested length read 0x00.
- R6: A write captures the first `length` MOSI bytes after the ready byte and ignores extra bytes. The captured bytes are committed, in order, with `we_o` high, after chip select rises. The commit happens only if all `length` bytes arrived.
- R7: Raising chip select at any point aborts the transaction and returns the target to header reception. A partial write commits nothing, and the next transaction behaves normally.
- R8: A 65th byte after the ready byte puts the target in an error state. Further input is ignored, nothing is committed, and normal service resumes after chip select rises.
- R9: `miso_oe_o` is low while chip select is high and after reset, and high while chip select is low.
- R10: `req_o` stays high with stable `addr_o`, `we_o` and `wdata_o` until `ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from host |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Host-to-target data |
| miso_o | output | 1 | Target-to-host data |
| miso_oe_o | output | 1 | MISO output enable (tri-state control) |
| req_o | output | 1 | Local access request |
| we_o | output | 1 | Local access is a write |
| addr_o | output | 24 | Local register offset |
| wdata_o | output | 8 | Local write data |
| rdata_i | input | 8 | Local read data |
| ack_i | input | 1 | Local access acknowledge, one cycle |

## Verification
A wrong framing state shows up at once as a misplaced ready byte: a write that stalls, a read whose fourth byte is already 0x01, or a ready byte that comes before the last local acknowledge. A bad buffer index or offset shows up as wrong payload bytes on MISO within the same transaction, or as committed writes whose address or data do not match the queued expectation. A stale state after an abort or an overflow shows up on the very next transaction's header bytes, or as a commit that should never have happened, a few cycles after chip select rises.

// File: rtl/spi_reg_pkg.sv
`timescale 1ns/1ps
package spi_reg_pkg;
  typedef enum logic [2:0] {
    ST_HDR, ST_WAIT, ST_DATA, ST_ERR, ST_COMMIT
  } tgt_state_e;

  localparam logic [7:0] BYTE_WAIT  = 8'h00;
  localparam logic [7:0] BYTE_READY = 8'h01;
  localparam int         HDR_BYTES  = 4;
endpackage

// File: rtl/spi_pin_sync.sv
`timescale 1ns/1ps
module spi_pin_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_byte_shift.sv
`timescale 1ns/1ps
module spi_byte_shift #(
  parameter int DW = 8,
  localparam int BW = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_act_i,
  input  logic          mosi_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          tx_load_o,
  output logic          rx_valid_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          miso_o,
  output logic          cs_start_o,
  output logic          cs_end_o
);
  logic          sclk_q, cs_q, miso_q;
  logic [BW-1:0] bit_cnt;
  logic [DW-2:0] rx_sr, tx_sr;
  logic          rise, fall;

  assign rise       = sclk_i & ~sclk_q & cs_act_i;
  assign fall       = ~sclk_i & sclk_q & cs_act_i;
  assign cs_start_o = cs_act_i & ~cs_q;
  assign cs_end_o   = ~cs_act_i & cs_q;
  // next byte is loaded at chip-select start and on the falling edge after a byte
  assign tx_load_o  = cs_start_o | (fall & (bit_cnt == '0));
  assign miso_o     = miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b0;
      miso_q     <= 1'b0;
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      sclk_q     <= sclk_i;
      cs_q       <= cs_act_i;
      rx_valid_o <= 1'b0;
      if (cs_start_o) bit_cnt <= '0;
      if (tx_load_o) begin
        miso_q <= tx_byte_i[DW-1];
        tx_sr  <= tx_byte_i[DW-2:0];
      end else if (fall) begin
        miso_q <= tx_sr[DW-2];
        tx_sr  <= {tx_sr[DW-3:0], 1'b0};
      end
      if (rise) begin
        rx_sr   <= {rx_sr[DW-3:0], mosi_i};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BW'(DW-1)) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {rx_sr, mosi_i};
        end
      end
    end
  end
endmodule

// File: rtl/spi_reg_target.sv
`timescale 1ns/1ps
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int              ADDR_W   = 24,
  parameter int              MAX_LEN  = 64,
  parameter logic [ADDR_W-1:0] WIN_BASE = 24'hD40000,
  localparam int LEN_W = $clog2(MAX_LEN),
  localparam int CNT_W = LEN_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wdata_o,
  input  logic [7:0]        rdata_i,
  input  logic              ack_i
);
  logic sclk_s, cs_act, mosi_s;
  logic tx_load, rx_valid, cs_start, cs_end;
  logic [7:0] rx_byte, tx_next;
  logic hdr_unused;

  spi_pin_sync #(.W(3)) u_sync (
    .clk_i, .rst_ni,
    .d_i({sclk_i, ~cs_ni, mosi_i}),
    .q_o({sclk_s, cs_act, mosi_s})
  );

  spi_byte_shift #(.DW(8)) u_shift (
    .clk_i, .rst_ni,
    .sclk_i(sclk_s), .cs_act_i(cs_act), .mosi_i(mosi_s),
    .tx_byte_i(tx_next), .tx_load_o(tx_load),
    .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
    .miso_o(miso_o), .cs_start_o(cs_start), .cs_end_o(cs_end)
  );

  tgt_state_e        st;
  logic [1:0]        hdr_cnt;
  logic              dir_rd, sent_rdy, loc_busy, fetch_done, abort_q;
  logic [LEN_W-1:0]  len_m1, lcnt;
  logic [CNT_W-1:0]  data_cnt, len;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        buf_q [MAX_LEN];
  logic              rx_wr, fe_wr, last_beat;

  assign hdr_unused = rx_byte[6];
  assign len        = CNT_W'(len_m1) + 1'b1;
  assign miso_oe_o  = cs_act;
  assign req_o      = loc_busy;
  assign we_o       = (st == ST_COMMIT);
  assign addr_o     = (addr_q - WIN_BASE) + ADDR_W'(lcnt);
  assign wdata_o    = buf_q[lcnt];
  assign last_beat  = (lcnt == len_m1) | abort_q;

  always_comb begin
    unique case (st)
      ST_HDR:  tx_next = (hdr_cnt == 2'd3 && !dir_rd) ? BYTE_READY : BYTE_WAIT;
      ST_WAIT: tx_next = fetch_done ? BYTE_READY : BYTE_WAIT;
      ST_DATA: tx_next = (dir_rd && data_cnt < len) ? buf_q[data_cnt[LEN_W-1:0]] : BYTE_WAIT;
      default: tx_next = BYTE_WAIT;
    endcase
  end

  assign rx_wr = rx_valid && st == ST_DATA && !dir_rd && data_cnt < len;
  assign fe_wr = loc_busy && ack_i && !we_o && !abort_q;

  always_ff @(posedge clk_i) begin
    if (fe_wr)      buf_q[lcnt] <= rdata_i;
    else if (rx_wr) buf_q[data_cnt[LEN_W-1:0]] <= rx_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_HDR; hdr_cnt <= '0; dir_rd <= 1'b0; len_m1 <= '0; addr_q <= '0;
      data_cnt <= '0; sent_rdy <= 1'b0; loc_busy <= 1'b0; lcnt <= '0;
      fetch_done <= 1'b0; abort_q <= 1'b0;
    end else begin
      if (tx_load) sent_rdy <= (st == ST_WAIT) & fetch_done;
      // local port engine
      if (loc_busy && ack_i) begin
        if (last_beat) begin
          loc_busy <= 1'b0;
          abort_q  <= 1'b0;
          if (we_o) st <= ST_HDR;
          else if (!abort_q) fetch_done <= 1'b1;
        end else begin
          lcnt <= lcnt + 1'b1;
        end
      end
      if (cs_end) begin
        hdr_cnt    <= '0;
        fetch_done <= 1'b0;
        if (st == ST_DATA && !dir_rd && data_cnt >= len) begin
          st       <= ST_COMMIT;
          loc_busy <= 1'b1;
          lcnt     <= '0;
        end else if (st != ST_COMMIT) begin
          st <= ST_HDR;
          if (loc_busy) abort_q <= 1'b1;
        end
      end else if (rx_valid) begin
        unique case (st)
          ST_HDR: begin
            hdr_cnt <= hdr_cnt + 1'b1;
            if (hdr_cnt == '0) begin
              dir_rd <= rx_byte[7];
              len_m1 <= rx_byte[LEN_W-1:0];
            end else begin
              addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
            end
            if (hdr_cnt == 2'd3) begin
              data_cnt <= '0;
              if (dir_rd) begin
                st <= ST_WAIT; loc_busy <= 1'b1; lcnt <= '0;
                fetch_done <= 1'b0; abort_q <= 1'b0;
              end else begin
                st <= ST_DATA;
              end
            end
          end
          ST_WAIT: if (sent_rdy) st <= ST_DATA;
          ST_DATA: begin
            if (data_cnt == CNT_W'(MAX_LEN)) st <= ST_ERR;
            else data_cnt <= data_cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o));
  // R4
  ready_after_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT && rx_valid && sent_rdy) |-> !loc_busy);
  // R4
  no_restall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_DATA |=> st != ST_WAIT);
  // R3
  stall_rd_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_WAIT |-> dir_rd);
  // R8
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st == ST_ERR && !cs_end |=> st == ST_ERR);
  // R6
  commit_wr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && we_o |-> !dir_rd && data_cnt >= len);
endmodule

// File: tb/spi_reg_target_test.sv
`timescale 1ns/1ps
module spi_reg_target_test;
  localparam int HALF = 80;
  localparam logic [23:0] BASE = 24'hD40000;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, miso_oe, req, we, ack = 0;
  logic [23:0] addr;
  logic [7:0] wdata, rdata = 0;

  int checks = 0, errors = 0, rd_acks = 0, hs_err = 0, lat_sel = 0, lat_cnt = 0;
  logic [31:0] exp_wq [$];
  logic pend = 0, p_we = 0;
  logic [23:0] p_addr = 0;
  logic [7:0] p_wd = 0;

  always #4 clk = ~clk;

  spi_reg_target uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .req_o(req), .we_o(we), .addr_o(addr),
    .wdata_o(wdata), .rdata_i(rdata), .ack_i(ack)
  );

  function automatic logic [7:0] mem_val(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] wr_val(input int i, input int seed);
    return 8'(i * 13 + seed);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // local responder with variable latency
  always @(posedge clk) begin
    ack <= 1'b0;
    if (req && !ack) begin
      if (lat_cnt == 0) begin
        ack <= 1'b1;
        rdata <= mem_val(addr);
        lat_cnt <= lat_sel % 4;
        lat_sel <= lat_sel + 1;
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  // monitor: write scoreboard, read ack counter, handshake stability (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (req && ack && we) begin
        if (exp_wq.size() == 0) chk(1'b0, "R6 unexpected local write", {addr, wdata}, 0);
        else begin
          logic [31:0] e;
          e = exp_wq.pop_front();
          chk({addr, wdata} == e, "R6 R2 committed write", {addr, wdata}, e);
        end
      end
      if (req && ack && !we) rd_acks++;
      if (pend && !(req && addr == p_addr && we == p_we && wdata == p_wd)) hs_err++;
      pend = req && !ack; p_addr = addr; p_we = we; p_wd = wdata;
    end
  end

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      #(HALF); sclk = 1; rx[i] = miso;
      #(HALF); sclk = 0;
    end
  endtask

  task automatic cs_low();
    cs_n = 0; #(200);
    chk(miso_oe == 1'b1, "R9 oe high under chip select", miso_oe, 1);
  endtask
  task automatic cs_high();
    #(HALF); cs_n = 1; #(400);
    chk(miso_oe == 1'b0, "R9 oe low after chip select", miso_oe, 0);
  endtask

  task automatic header(input logic rd, input int n, input logic [23:0] a, output logic [7:0] b3);
    logic [7:0] r;
    xfer({rd, 1'b0, 6'(n - 1)}, r); chk(r == 0, "R3 header byte 1", r, 0);
    xfer(a[23:16], r);              chk(r == 0, "R3 header byte 2", r, 0);
    xfer(a[15:8], r);               chk(r == 0, "R3 header byte 3", r, 0);
    xfer(a[7:0], b3);
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input int extra);
    logic [7:0] r;
    int polls;
    logic [23:0] off;
    off = a - BASE;
    rd_acks = 0;
    cs_low();
    header(1'b1, n, a, r);
    chk(r == 8'h00, "R3 R1 read fourth byte stalls", r, 0);
    polls = 0; r = 0;
    while (r != 8'h01 && polls < 1000) begin
      xfer(8'h00, r); polls++;
      if (r != 8'h00 && r != 8'h01) chk(1'b0, "R4 poll byte value", r, 1);
    end
    chk(r == 8'h01, "R4 ready byte seen", r, 1);
    chk(rd_acks == n, "R4 ready only after all local reads", rd_acks, n);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      chk(r == mem_val(off + 24'(i)), "R5 R2 read payload", r, mem_val(off + 24'(i)));
    end
    for (int i = 0; i < extra; i++) begin
      xfer(8'h00, r);
      chk(r == 8'h00, "R5 byte past length", r, 0);
    end
    cs_high();
  endtask

  task automatic do_write(input logic [23:0] a, input int n, input int sent, input int seed);
    logic [7:0] r;
    logic [23:0] off;
    off = a - BASE;
    if (sent >= n && sent <= 64)
      for (int i = 0; i < n; i++) exp_wq.push_back({off + 24'(i), wr_val(i, seed)});
    cs_low();
    header(1'b0, n, a, r);
    chk(r == 8'h01, "R3 R1 write fourth byte ready", r, 1);
    for (int i = 0; i < sent; i++) xfer(wr_val(i, seed), r);
    cs_high();
    for (int k = 0; k < 2000 && exp_wq.size() != 0; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(exp_wq.size() == 0, "R6 all expected writes committed", exp_wq.size(), 0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    chk(miso_oe == 1'b0 && req == 1'b0, "R9 reset state", {miso_oe, req}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    // R1 R2 R4 R5 reads
    do_read(24'hD40010, 4, 1);
    do_read(24'hD40000, 1, 0);
    do_read(24'hD40100, 64, 1);
    do_read(24'h000005, 3, 0);   // R2 offset wraps
    // R6 writes
    do_write(24'hD40020, 4, 4, 1);
    do_write(24'hD40200, 1, 1, 7);
    do_write(24'hD40300, 64, 64, 3);
    do_write(24'hD40040, 2, 5, 9);   // R6 extra bytes ignored
    // R7 partial write, no commit
    do_write(24'hD40050, 4, 2, 5);
    // R7 abort mid-header
    cs_low(); xfer(8'h83, r); xfer(8'hD4, r); cs_high();
    do_write(24'hD40060, 2, 2, 11);
    // R7 abort during read stall
    cs_low(); header(1'b1, 64, 24'hD40400, r); xfer(8'h00, r); cs_high();
    repeat (600) @(negedge clk);
    do_read(24'hD40070, 2, 0);
    // R8 overflow: 70 payload bytes, no commit, recovery
    do_write(24'hD40080, 4, 70, 2);
    do_read(24'hD40090, 4, 0);
    do_write(24'hD400A0, 3, 3, 4);
    chk(hs_err == 0, "R10 request held stable until ack", hs_err, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule